// File: doc/BRIEF.md
# Maskable Pin-Change Interrupt Latch with Alert Output

This block watches a small group of asynchronous I/O input pins and a thermal-shutdown flag, and turns any change it is allowed to report into a sticky interrupt. Each pin is first brought into the clock domain through a synchronizer chain. A change is then found by comparing the newest synchronized sample with the one before it. Each pin change that is not masked, and every rising edge of the thermal flag, sets a hardware interrupt latch. That latch drives the pull-down enable of an active-low, open-drain alert line.

A second latch holds a request for a software START-STOP interrupt. It is set by any pin change or thermal event, and it has a single mask of its own that does not depend on the per-pin masks. Both latches stay set after the cause has gone away. Only a clear pulse from the alert-response logic resets them, and an event that lands in the same cycle as that clear pulse keeps the latch set. The mask bits come from the active control register held outside this block. The serial protocol and the bus mastering that produces the START-STOP sequence are also outside this block.

Top module: `irq_alert_ctrl`

## Requirements
- R1: A change of level on pin i, with pin_mask[i] = 0, sets the alert latch, so alert_pull_low reads 1. A change on a pin whose mask bit is 1 does not set it.
- R2: A rising edge of thermal_in (0 in one cycle, 1 in the next) sets alert_pull_low one clock edge later, whatever the value of pin_mask.
- R3: Once alert_pull_low is 1, it stays 1 until clear_pulse is sampled high, even when the pin or thermal cause has gone away.
- R4: ss_req is set by any pin change, whatever pin_mask is, and by a thermal rising edge, but only while ss_mask = 0. ss_req is never set while ss_mask = 1.
- R5: When clear_pulse is sampled high at a clock edge with no new event in that cycle, both alert_pull_low and ss_req read 0 after that edge.
- R6: An event seen in the same cycle as clear_pulse takes priority, and the affected latch stays at 1.
- R7: After reset, alert_pull_low and ss_req are 0. Pin levels already present when reset is released are not treated as changes.
- R8: A pin change shows on the outputs exactly SYNC_STAGES+1 clock edges after the input moves, and not earlier. With the default of 2 stages this is 3 edges.
- R9: With every mask bit at 1 (pin_mask all ones, ss_mask = 1), which is the mask register's power-on state, pin changes raise neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pin_async | input | NUM_PINS | Raw I/O pin levels, not synchronized |
| thermal_in | input | 1 | Thermal-shutdown flag, synchronous, level |
| pin_mask | input | NUM_PINS | Per-pin alert mask; 1 masks that pin |
| ss_mask | input | 1 | START-STOP request mask; 1 masks all sources |
| clear_pulse | input | 1 | One-cycle clear from a successful alert response |
| alert_pull_low | output | 1 | 1 = drive the open-drain alert line low |
| ss_req | output | 1 | Pending software START-STOP interrupt request |

## Verification
The pin-change path is driven with a table of pin transitions paired with different mask combinations. These include a single unmasked pin, a change hidden by its mask, several pins changing together under a partial mask, no change at all under open masks, and changes that reach only the START-STOP path. This separates per-pin gating from the independent START-STOP gating. Directed patterns then cover the following:
- pins held high through reset, to rule out false changes at start-up;
- the exact synchronizer latency;
- a one-cycle pin glitch, to show the latch holds;
- a thermal edge under full masking;
- a clear pulse that coincides with a new event.

// File: rtl/irq_alert_pkg.sv
package irq_alert_pkg;
   localparam int unsigned DEF_NUM_PINS    = 3;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // Reduce a masked change vector to a single request bit.
   function automatic logic any_unmasked(input logic [31:0] chg,
                                         input logic [31:0] msk);
      return |(chg & ~msk);
   endfunction
endpackage

// File: rtl/pin_change_det.sv
module pin_change_det #(
   parameter int unsigned NUM_PINS    = irq_alert_pkg::DEF_NUM_PINS,
   parameter int unsigned SYNC_STAGES = irq_alert_pkg::DEF_SYNC_STAGES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_async,
   output logic [NUM_PINS-1:0] chg
);
   localparam int unsigned ARM_AT = SYNC_STAGES + 1;
   localparam int unsigned CW     = $clog2(ARM_AT + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("pin_change_det: SYNC_STAGES must be at least 2");
      end
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("pin_change_det: NUM_PINS must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0][NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0]                  prev_q;
   logic [CW-1:0]                        arm_cnt;
   logic                                 armed;

   // Synchronizer chain followed by one history register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   // Detection starts only once the chain and the history hold real samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm_cnt <= '0;
      else if (!armed) arm_cnt <= arm_cnt + 1'b1;
   end

   assign armed = (arm_cnt == CW'(ARM_AT));
   assign chg   = armed ? (sync_q[SYNC_STAGES-1] ^ prev_q) : '0;

   // R7: while not yet armed, no change is reported
   assert_no_early_change_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (arm_cnt < CW'(ARM_AT)) |-> (chg == '0));
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic q
);
   // Set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_evt) q <= 1'b1;
      else if (clr)     q <= 1'b0;
   end

   assert_sticky_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);
   assert_clear_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_evt) |=> !q);
   assert_event_wins_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> q);
endmodule

// File: rtl/irq_alert_ctrl.sv
module irq_alert_ctrl #(
   parameter int unsigned NUM_PINS    = irq_alert_pkg::DEF_NUM_PINS,
   parameter int unsigned SYNC_STAGES = irq_alert_pkg::DEF_SYNC_STAGES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_async,
   input  logic                thermal_in,
   input  logic [NUM_PINS-1:0] pin_mask,
   input  logic                ss_mask,
   input  logic                clear_pulse,
   output logic                alert_pull_low,
   output logic                ss_req
);
   generate
      if (NUM_PINS > 32) begin : g_too_wide
         $error("irq_alert_ctrl: NUM_PINS limited to 32");
      end
   endgenerate

   logic [NUM_PINS-1:0] chg;
   logic                therm_q;
   logic                therm_rise;
   logic                hw_set;
   logic                ss_set;

   pin_change_det #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_async),
      .chg       (chg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) therm_q <= 1'b0;
      else        therm_q <= thermal_in;
   end

   assign therm_rise = thermal_in & ~therm_q;

   // The thermal edge bypasses every mask on the alert path
   assign hw_set = irq_alert_pkg::any_unmasked(32'(chg), 32'(pin_mask)) | therm_rise;
   assign ss_set = ~ss_mask & ((|chg) | therm_rise);

   irq_latch u_hw (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (hw_set),
      .clr     (clear_pulse),
      .q       (alert_pull_low)
   );

   irq_latch u_ss (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (ss_set),
      .clr     (clear_pulse),
      .q       (ss_req)
   );

   assert_ss_masked_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ss_mask && !ss_req) |=> !ss_req);
   assert_thermal_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      therm_rise |=> alert_pull_low);
   assert_masked_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!alert_pull_low && (&pin_mask) && !therm_rise) |=> !alert_pull_low);
endmodule

// File: tb/sim_irq_alert_ctrl.sv
`timescale 1ns/1ps
module sim_irq_alert_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] pin_async = 3'b111;
   logic       thermal_in = 1'b0;
   logic [2:0] pin_mask = 3'b000;
   logic       ss_mask = 1'b0;
   logic       clear_pulse = 1'b0;
   logic       alert_pull_low;
   logic       ss_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_alert_ctrl u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .pin_async      (pin_async),
      .thermal_in     (thermal_in),
      .pin_mask       (pin_mask),
      .ss_mask        (ss_mask),
      .clear_pulse    (clear_pulse),
      .alert_pull_low (alert_pull_low),
      .ss_req         (ss_req)
   );

   // {new pins[3], pin_mask[3], ss_mask, expected alert, expected ss_req}
   localparam logic [8:0] VEC [0:7] = '{
      9'b001_111_1_0_0,   // R9 all masked
      9'b011_101_1_1_0,   // R1 pin1 unmasked
      9'b010_110_1_1_0,   // R1 pin0 unmasked
      9'b110_011_0_1_1,   // R1 R4 pin2 unmasked, ss open
      9'b100_111_0_0_1,   // R4 ss ignores pin masks
      9'b100_000_0_0_0,   // R1 no change, nothing set
      9'b011_111_1_0_0,   // R1 all changes masked
      9'b000_100_1_1_0    // R1 two unmasked changes
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_clear();
      clear_pulse = 1'b1;
      tick(1);
      clear_pulse = 1'b0;
   endtask

   initial begin
      // R7: pins high through reset, all masks open
      tick(3);
      rst_n = 1'b1;
      tick(6);
      check("R7 alert after reset", alert_pull_low, 1'b0);
      check("R7 ss_req after reset", ss_req, 1'b0);

      // R9: fully masked pin change
      pin_mask = 3'b111; ss_mask = 1'b1;
      pin_async = 3'b000;
      tick(5);
      check("R9 alert with all masks", alert_pull_low, 1'b0);
      check("R9 ss_req with all masks", ss_req, 1'b0);

      // Table walk: R1 / R4
      for (int i = 0; i < 8; i++) begin
         pin_mask = VEC[i][5:3];
         ss_mask  = VEC[i][2];
         do_clear();
         pin_async = VEC[i][8:6];
         tick(3);
         check("R1 table alert", alert_pull_low, VEC[i][1]);
         check("R4 table ss_req", ss_req, VEC[i][0]);
         tick(2);
      end

      // R8: latency of exactly three edges
      pin_mask = 3'b000; ss_mask = 1'b1;
      do_clear();
      pin_async = 3'b001;
      tick(2);
      check("R8 alert not early", alert_pull_low, 1'b0);
      tick(1);
      check("R8 alert on third edge", alert_pull_low, 1'b1);

      // R3: one-cycle glitch stays latched
      tick(3);
      do_clear();
      check("R5 cleared before glitch", alert_pull_low, 1'b0);
      pin_async = 3'b011;
      tick(1);
      pin_async = 3'b001;
      tick(10);
      check("R3 glitch latched", alert_pull_low, 1'b1);

      // R2: thermal with every mask set
      pin_mask = 3'b111; ss_mask = 1'b1;
      do_clear();
      thermal_in = 1'b1;
      tick(1);
      check("R2 thermal alert", alert_pull_low, 1'b1);
      check("R4 thermal ss masked", ss_req, 1'b0);
      thermal_in = 1'b0;
      tick(5);
      check("R3 alert held after thermal gone", alert_pull_low, 1'b1);
      do_clear();
      check("R5 alert cleared", alert_pull_low, 1'b0);
      check("R5 ss cleared", ss_req, 1'b0);

      // R4: thermal into ss path
      ss_mask = 1'b0;
      thermal_in = 1'b1;
      tick(1);
      check("R4 thermal ss open", ss_req, 1'b1);
      thermal_in = 1'b0;
      tick(2);
      do_clear();
      check("R5 ss cleared again", ss_req, 1'b0);
      check("R5 alert cleared again", alert_pull_low, 1'b0);

      // R6: event coincides with clear
      clear_pulse = 1'b1;
      thermal_in  = 1'b1;
      tick(1);
      clear_pulse = 1'b0;
      check("R6 alert event wins", alert_pull_low, 1'b1);
      check("R6 ss event wins", ss_req, 1'b1);
      thermal_in = 1'b0;
      tick(2);
      do_clear();
      check("R5 final clear", alert_pull_low, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule